// File: doc/BRIEF.md
# Codec Serial Byte Link

This block connects a simple processor register port to a serial audio codec. Software writes bytes into an 8-bit data port, and each write is queued in a 16-entry transmit FIFO. Reading the same port takes the oldest byte from a 16-entry receive FIFO. A byte-slot engine runs continuously while the codec function is selected. At the start of each slot it takes the next queued byte and shifts it to the codec one bit at a time, MSB first. Over the same slot it assembles the byte arriving from the codec and queues it for software.

The bit rate is a fixed division of the system clock, set by the parameter `BIT_DIV`, and one slot lasts eight bit periods. With the default divider and a 4.096 MHz clock, the slot rate is 8000 bytes per second. The interrupt is not tied to FIFO fill levels. It is a one-cycle pulse raised once per eight completed slots, which gives 1 kHz at the nominal rate. Software reads the full and empty flags of both FIFOs directly.

The link is active only while the codec select input is high. Clearing that input stops the slot engine, flushes both FIFOs and restarts the interrupt count.

Top module: `codec_byte_link`

## Requirements
- R1: After reset, both empty flags are 1, both full flags are 0, and `irq`, `cdc_fsync` and `cdc_dout` are 0.
- R2: While `codec_sel` is 1, a write stores `wr_data` in the transmit FIFO. Once 16 bytes are held, `tx_full` is 1 and further writes are discarded.
- R3: Each slot lasts 8 × `BIT_DIV` cycles, and slots follow each other without gaps. The byte is sent MSB first, one bit per `BIT_DIV` cycles. `cdc_fsync` is 1 only during the first bit period, and `cdc_bclk` is 1 in the first cycle of every bit period.
- R4: The first slot starts on the first clock after `codec_sel` rises. Each slot sends the oldest transmit byte, or 0x00 if the transmit FIFO is empty when the slot starts.
- R5: `cdc_din` is sampled once per bit period, MSB first. At the end of each slot the assembled byte is queued in the receive FIFO. `rd_data` shows the oldest entry without popping it, and a read removes it.
- R6: When the receive FIFO already holds 16 bytes, a newly completed byte is dropped and `rx_full` stays 1.
- R7: `irq` is a one-cycle pulse. It is raised in the first cycle of the slot that follows every eighth completed slot since the link was enabled.
- R8: While `codec_sel` is 0, both FIFOs are flushed, the slot and interrupt counters are cleared, `irq`, `cdc_fsync` and `cdc_dout` stay 0, and writes and reads have no effect.
- R9: `tx_empty`, `tx_full`, `rx_empty` and `rx_full` follow the number of bytes held in each FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| codec_sel | input | 1 | Selects and enables the codec link |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 8 | Byte to queue for transmission |
| rd_en | input | 1 | Data port read strobe (pops receive FIFO) |
| rd_data | output | 8 | Oldest received byte (0 when empty) |
| tx_full | output | 1 | Transmit FIFO holds 16 bytes |
| tx_empty | output | 1 | Transmit FIFO holds no bytes |
| rx_full | output | 1 | Receive FIFO holds 16 bytes |
| rx_empty | output | 1 | Receive FIFO holds no bytes |
| irq | output | 1 | One-cycle pulse per eight completed slots |
| cdc_bclk | output | 1 | Bit clock to the codec |
| cdc_fsync | output | 1 | Frame marker, high during the first bit of a slot |
| cdc_dout | output | 1 | Serial data to the codec |
| cdc_din | input | 1 | Serial data from the codec |

## Verification
The transmit side runs in three regimes: an idle FIFO, which must produce 0x00 slots; a burst of seventeen writes, which must come out in order with the seventeenth lost; and a FIFO that drains back to empty. The transmit patterns include bytes with a lone MSB or a lone LSB set, so a reversed bit order or a shift by one bit shows up.

The receive side is given a distinct byte in every slot. It is then read back only after more than sixteen slots, so an overrun that overwrote old entries rather than dropping new ones would return the wrong sequence.

The sequence is then repeated across a disable and re-enable. This separates a true flush from a stale FIFO, and a cleared interrupt count from a carried-over one.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cl_fifo.sv
module cl_fifo
    import codec_link_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  push,
    input  byte_t wdata,
    input  logic  pop,
    output byte_t rdata,
    output logic  full,
    output logic  empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    byte_t    mem_q [DEPTH];
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = nxt(st_q.wp);
            if (do_pop)  st_d.rp = nxt(st_q.rp);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full));
endmodule

// File: rtl/cl_slot_engine.sv
module cl_slot_engine
    import codec_link_pkg::*;
#(
    parameter int BIT_DIV = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  tx_avail,
    input  byte_t tx_byte,
    output logic  tx_pop,
    output logic  rx_push,
    output byte_t rx_byte,
    output logic  slot_done,
    output logic  sbclk,
    output logic  sfsync,
    output logic  sdout,
    input  logic  sdin
);
    localparam int DW   = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam int HALF = (BIT_DIV - 1) / 2;
    localparam int BW   = $clog2(BYTE_W);

    typedef struct packed {
        logic          active;
        logic [DW-1:0] div;
        logic [BW-1:0] bitn;
        byte_t         tx_sh;
        byte_t         rx_sh;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    last_div, slot_end;

    assign last_div  = (st_q.div == DW'(BIT_DIV - 1));
    assign slot_end  = st_q.active && last_div && (st_q.bitn == BW'(BYTE_W - 1));
    assign rx_byte   = st_q.rx_sh;
    assign sfsync    = st_q.active && (st_q.bitn == '0);
    assign sbclk     = st_q.active && (st_q.div <= DW'(HALF));
    assign sdout     = st_q.active && st_q.tx_sh[BYTE_W-1];

    always_comb begin
        st_d      = st_q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        slot_done = 1'b0;
        if (!en) begin
            st_d = '0;
        end else begin
            if (st_q.active) begin
                if (st_q.div == DW'(HALF))
                    st_d.rx_sh = {st_q.rx_sh[BYTE_W-2:0], sdin};
                if (last_div) begin
                    st_d.div   = '0;
                    st_d.bitn  = st_q.bitn + BW'(1);
                    st_d.tx_sh = {st_q.tx_sh[BYTE_W-2:0], 1'b0};
                end else begin
                    st_d.div = st_q.div + DW'(1);
                end
            end
            if (slot_end) begin
                rx_push   = 1'b1;
                slot_done = 1'b1;
            end
            if (!st_q.active || slot_end) begin
                st_d.active = 1'b1;
                st_d.div    = '0;
                st_d.bitn   = '0;
                tx_pop      = tx_avail;
                st_d.tx_sh  = tx_avail ? tx_byte : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    fsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sfsync) && en) |=> sfsync);

    // R5
    push_then_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && en) |=> sfsync);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sfsync && !sdout && !rx_push));
endmodule

// File: rtl/cl_irq_gen.sv
module cl_irq_gen #(
    parameter int SLOTS_PER_IRQ = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slot_done,
    output logic irq
);
    localparam int CW = (SLOTS_PER_IRQ > 1) ? $clog2(SLOTS_PER_IRQ) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    assign irq = st_q.irq;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (slot_done) begin
            if (st_q.cnt == CW'(SLOTS_PER_IRQ - 1)) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);
endmodule

// File: rtl/codec_byte_link.sv
module codec_byte_link
    import codec_link_pkg::*;
#(
    parameter int BIT_DIV       = 64,
    parameter int FIFO_DEPTH    = 16,
    parameter int SLOTS_PER_IRQ = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       codec_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       tx_full,
    output logic       tx_empty,
    output logic       rx_full,
    output logic       rx_empty,
    output logic       irq,
    output logic       cdc_bclk,
    output logic       cdc_fsync,
    output logic       cdc_dout,
    input  logic       cdc_din
);
    logic  flush, tx_pop, rx_push, slot_done;
    byte_t tx_head, rx_byte;

    assign flush = !codec_sel;

    cl_fifo #(.DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (codec_sel && wr_en),
        .wdata (wr_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    cl_fifo #(.DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (codec_sel && rd_en),
        .rdata (rd_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    cl_slot_engine #(.BIT_DIV(BIT_DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (codec_sel),
        .tx_avail  (!tx_empty),
        .tx_byte   (tx_head),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .slot_done (slot_done),
        .sbclk     (cdc_bclk),
        .sfsync    (cdc_fsync),
        .sdout     (cdc_dout),
        .sdin      (cdc_din)
    );

    cl_irq_gen #(.SLOTS_PER_IRQ(SLOTS_PER_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (codec_sel),
        .slot_done (slot_done),
        .irq       (irq)
    );

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    // R4
    pop_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> cdc_fsync);
endmodule

// File: tb/codec_byte_link_test.sv
`timescale 1ns/1ps
module codec_byte_link_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       codec_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_full, tx_empty, rx_full, rx_empty, irq;
    logic       cdc_bclk, cdc_fsync, cdc_dout;
    logic       cdc_din = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int done_slots = 0;
    bit last_fs = 1'b0;

    always #2.5 clk = ~clk;

    codec_byte_link #(.BIT_DIV(DIV), .FIFO_DEPTH(16), .SLOTS_PER_IRQ(8)) uut (
        .clk(clk), .rst_n(rst_n), .codec_sel(codec_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .irq(irq), .cdc_bclk(cdc_bclk), .cdc_fsync(cdc_fsync), .cdc_dout(cdc_dout),
        .cdc_din(cdc_din)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] tx_pat(input int i);
        return (i == 0) ? 8'h80 : (i == 1) ? 8'h01 : 8'(8'h3C + i * 8'h17);
    endfunction

    function automatic logic [7:0] din_pat(input int i);
        return 8'(8'hA5 ^ (i * 8'h29));
    endfunction

    // Runs one slot: drives the incoming byte, collects the outgoing byte,
    // and checks framing and the interrupt pulse.
    task automatic run_slot(input logic [7:0] exp_tx, input logic [7:0] din_b, input string req);
        logic [7:0] got;
        bit frame_ok;
        bit extra_irq;
        bit irq_exp;
        forever begin
            @(negedge clk);
            if (cdc_fsync && !last_fs) break;
            last_fs = cdc_fsync;
        end
        irq_exp = (done_slots > 0) && (done_slots % 8 == 0);
        // R7: pulse in first cycle after every eighth slot
        check(irq == irq_exp, "R7 irq at slot start", int'(irq), int'(irq_exp));
        got = 8'h00; frame_ok = 1'b1; extra_irq = 1'b0;
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < DIV; c++) begin
                if (!(k == 0 && c == 0)) @(negedge clk);
                if (c == 0) begin
                    cdc_din = din_b[7-k];
                    got[7-k] = cdc_dout;
                    if (!cdc_bclk) frame_ok = 1'b0;
                end
                if (cdc_fsync != (k == 0)) frame_ok = 1'b0;
                if (!(k == 0 && c == 0) && irq) extra_irq = 1'b1;
            end
        end
        last_fs = 1'b0;
        done_slots++;
        check(got == exp_tx, req, int'(got), int'(exp_tx));
        // R3: framing of the slot
        check(frame_ok, "R3 fsync/bclk framing", int'(frame_ok), 1);
        // R7: single-cycle pulse
        check(!extra_irq, "R7 irq width", int'(extra_irq), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(tx_empty && rx_empty, "R1 empty flags", {tx_empty, rx_empty}, 3);
        check(!tx_full && !rx_full, "R1 full flags", {tx_full, rx_full}, 0);
        check(!irq && !cdc_fsync && !cdc_dout, "R1 idle outputs", {irq, cdc_fsync, cdc_dout}, 0);
    endtask

    task automatic t_fill_and_drain;
        @(negedge clk);
        codec_sel = 1'b1;
        done_slots = 0;
        last_fs = 1'b0;
        fork
            run_slot(8'h00, din_pat(0), "R4 empty FIFO sends 0x00");
            begin
                for (int i = 0; i < 17; i++) begin
                    @(negedge clk);
                    wr_en = 1'b1;
                    wr_data = tx_pat(i);
                end
                @(negedge clk);
                wr_en = 1'b0;
                // R2: 16 bytes make the FIFO full
                check(tx_full == 1'b1, "R2 tx_full after 17 writes", int'(tx_full), 1);
                // R9
                check(tx_empty == 1'b0, "R9 tx_empty while full", int'(tx_empty), 0);
            end
        join
        for (int s = 1; s < 18; s++)
            run_slot((s <= 16) ? tx_pat(s - 1) : 8'h00, din_pat(s), "R2 R4 serialized byte");
        // R6: 18 slots completed minus the current, receive FIFO saturated
        check(rx_full == 1'b1, "R6 rx_full", int'(rx_full), 1);
        // R9: transmit FIFO drained
        check(tx_empty == 1'b1, "R9 tx_empty after drain", int'(tx_empty), 1);
        @(negedge clk);
        begin
            bit data_ok = 1'b1;
            logic [7:0] bad_got = 8'h00;
            logic [7:0] bad_exp = 8'h00;
            for (int i = 0; i < 16; i++) begin
                if (rd_data != din_pat(i) && data_ok) begin
                    data_ok = 1'b0; bad_got = rd_data; bad_exp = din_pat(i);
                end
                rd_en = 1'b1;
                @(negedge clk);
            end
            rd_en = 1'b0;
            // R5 R6: first sixteen received bytes in order, later ones dropped
            check(data_ok, "R5 R6 receive order", int'(bad_got), int'(bad_exp));
        end
        check(rx_empty == 1'b1, "R5 rx_empty after 16 reads", int'(rx_empty), 1);
    endtask

    task automatic t_disable;
        for (int i = 0; i < 5; i++) begin
            wr_en = 1'b1; wr_data = 8'hE0 + 8'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        repeat (40) @(negedge clk);
        // R9: both FIFOs hold data before the disable
        check(!tx_empty && !rx_empty, "R9 occupancy before disable", {tx_empty, rx_empty}, 0);
        codec_sel = 1'b0;
        @(negedge clk);
        // R8
        check(tx_empty && rx_empty, "R8 flush on disable", {tx_empty, rx_empty}, 3);
        check(!irq && !cdc_fsync && !cdc_dout, "R8 quiet while off", {irq, cdc_fsync, cdc_dout}, 0);
        wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check(tx_empty == 1'b1, "R8 write ignored while off", int'(tx_empty), 1);
        codec_sel = 1'b1;
        done_slots = 0;
        last_fs = 1'b0;
        for (int s = 0; s < 9; s++)
            run_slot(8'h00, din_pat(40 + s), "R8 no stale transmit byte");
        @(negedge clk);
        check(rd_data == din_pat(40), "R8 receive restarts after flush", int'(rd_data), int'(din_pat(40)));
    endtask

    initial begin
        t_reset();
        t_fill_and_drain();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule